// File: doc/BRIEF.md
# Sync-Referenced Clamp Pulse Generator

This block sits in the pixel clock domain of a video capture front end. It takes a raw horizontal sync line, an optional external clamp line and an optional coast line, and brings all three into the clock domain through two-flop synchronizers. From the synchronized sync it derives a one-cycle strobe on the leading edge, which is the timing reference. It also derives a clamp window, which tells the analog front end when the input carries black.

The clamp window comes from one of two places. In internal mode a counter opens the window a programmed number of cycles after the sync trailing edge and keeps it open for a programmed number of cycles. In external mode the synchronized clamp pin, at its programmed active level, drives the window directly. The coast output follows the coast pin at its own programmed level. The downstream clock generator uses it to hold its frequency and phase instead of tracking sync.

The polarity bits, the mode bit, the delay and the width are held in a small configuration register. That register loads while `cfg_we` is high and has its own reset value for each field.

Top module: `hsync_clamp_gen`

## Requirements
- R1: With `sync_pol`=0 the leading edge of `hsync_in` is a 1-to-0 transition; with `sync_pol`=1 it is a 0-to-1 transition. The opposite transition is the trailing edge. If an input transition is first sampled at clock edge k, `lead_strobe` is high after edge k+2 for exactly one cycle.
- R2: `lead_strobe` is produced for a leading edge whether or not coast is active.
- R3: In internal mode, a trailing edge first sampled at edge k gives `clamp_win` high after edges k+2+D through k+1+D+W, where D is the 8-bit delay and W is the 8-bit width, both counted in pixel clocks.
- R4: A trailing edge that arrives while a delay or window is counting restarts the count from zero on that edge.
- R5: A width of 0 produces no clamp window.
- R6: With the external-clamp bit at 1, `clamp_win` equals the synchronized `clamp_in` at its active level (`clamp_pol`=1 active high, 0 active low). It follows a pin change sampled at edge k after edge k+1, and the sync edges do not affect it.
- R7: With the external-clamp bit at 0, `clamp_in` has no effect on `clamp_win`.
- R8: `coast_out` is high whenever the synchronized `coast_in` is at its active level (`coast_pol`=1 active high, 0 active low). It follows a pin change sampled at edge k after edge k+1.
- R9: Reset sets `sync_pol`=0, `clamp_pol`=0, `coast_pol`=1, external clamp off, delay=4 and width=8, and drives `lead_strobe` and `clamp_win` low.
- R10: The configuration changes only on a clock edge where `cfg_we` is 1. Changes on the configuration inputs while `cfg_we` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Raw horizontal sync |
| clamp_in | input | 1 | Raw external clamp |
| coast_in | input | 1 | Raw coast request |
| cfg_we | input | 1 | Load the configuration fields below |
| cfg_sync_pol | input | 1 | Sync leading-edge sense |
| cfg_clamp_pol | input | 1 | External clamp active level |
| cfg_coast_pol | input | 1 | Coast active level |
| cfg_ext_clamp | input | 1 | 1 selects the external clamp pin |
| cfg_delay | input | CNT_W | Cycles from trailing edge to window start |
| cfg_width | input | CNT_W | Window length in cycles |
| lead_strobe | output | 1 | One-cycle leading-edge pulse |
| clamp_win | output | 1 | Active-high clamp window |
| coast_out | output | 1 | Active-high coast flag |

## Verification
Any wrong counter or state value shows up on `clamp_win` within one line. The window opens early, opens late, runs the wrong length or never closes. The bench therefore measures the first high cycle and the run length of each window against the trailing edge that started it. A stale edge-detect flop or a wrong polarity bit shows up two cycles after the input transition, as a missing, doubled or misplaced `lead_strobe`. A mode or polarity register error shows up one cycle after the pin changes, as `clamp_win` or `coast_out` at the wrong level.

// File: rtl/hsync_clamp_gen.sv
module hsync_clamp_gen #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_RST   = 4,
  parameter int WIDTH_RST   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             clamp_in,
  input  logic             coast_in,
  input  logic             cfg_we,
  input  logic             cfg_sync_pol,
  input  logic             cfg_clamp_pol,
  input  logic             cfg_coast_pol,
  input  logic             cfg_ext_clamp,
  input  logic [CNT_W-1:0] cfg_delay,
  input  logic [CNT_W-1:0] cfg_width,
  output logic             lead_strobe,
  output logic             clamp_win,
  output logic             coast_out
);

  localparam int HS_LEN = SYNC_STAGES + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_OPEN} win_st_e;

  logic             sync_pol_q, clamp_pol_q, coast_pol_q, ext_en_q;
  logic [CNT_W-1:0] dly_q, wid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_pol_q  <= 1'b0;
      clamp_pol_q <= 1'b0;
      coast_pol_q <= 1'b1;
      ext_en_q    <= 1'b0;
      dly_q       <= CNT_W'(DELAY_RST);
      wid_q       <= CNT_W'(WIDTH_RST);
    end else if (cfg_we) begin
      sync_pol_q  <= cfg_sync_pol;
      clamp_pol_q <= cfg_clamp_pol;
      coast_pol_q <= cfg_coast_pol;
      ext_en_q    <= cfg_ext_clamp;
      dly_q       <= cfg_delay;
      wid_q       <= cfg_width;
    end
  end

  logic [HS_LEN-1:0]      hs_sh;
  logic [SYNC_STAGES-1:0] cl_sh, co_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_sh <= '1;
      cl_sh <= '0;
      co_sh <= '0;
    end else begin
      hs_sh <= {hs_sh[HS_LEN-2:0], hsync_in};
      cl_sh <= {cl_sh[SYNC_STAGES-2:0], clamp_in};
      co_sh <= {co_sh[SYNC_STAGES-2:0], coast_in};
    end
  end

  wire act_now = hs_sh[HS_LEN-2] ~^ sync_pol_q;
  wire act_old = hs_sh[HS_LEN-1] ~^ sync_pol_q;
  wire lead_c  = act_now & ~act_old;
  wire trail_c = ~act_now & act_old;

  always_ff @(posedge clk) begin
    if (!rst_n) lead_strobe <= 1'b0;
    else        lead_strobe <= lead_c;
  end

  win_st_e          st;
  logic [CNT_W-1:0] cnt;
  wire  [CNT_W:0]   cnt_nx = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (trail_c) begin
      cnt <= '0;
      if (wid_q == '0)      st <= ST_IDLE;
      else if (dly_q == '0) st <= ST_OPEN;
      else                  st <= ST_WAIT;
    end else begin
      case (st)
        ST_WAIT: begin
          if (cnt_nx == {1'b0, dly_q}) begin
            st  <= ST_OPEN;
            cnt <= '0;
          end else cnt <= cnt_nx[CNT_W-1:0];
        end
        ST_OPEN: begin
          if (cnt_nx == {1'b0, wid_q}) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else cnt <= cnt_nx[CNT_W-1:0];
        end
        default: cnt <= '0;
      endcase
    end
  end

  wire win_int = (st == ST_OPEN);
  wire ext_act = cl_sh[SYNC_STAGES-1] ~^ clamp_pol_q;

  assign clamp_win = ext_en_q ? ext_act : win_int;
  assign coast_out = co_sh[SYNC_STAGES-1] ~^ coast_pol_q;

  // R1: the strobe never lasts longer than one cycle
  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    lead_strobe |=> !lead_strobe);

  // R4: any trailing edge restarts the count
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    trail_c |=> (cnt == '0));

  // R5: a zero width never opens the window
  a_r5_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_c && wid_q == '0) |=> !win_int);

  // R3: the internal window opens only from a trailing edge or the end of a delay
  a_r3_open_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_int) |-> ($past(trail_c) || $past(st) == ST_WAIT));

  // R6: in external mode a rising pin level reaches the window at once
  a_r6_ext_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ext_act) && ext_en_q && $past(ext_en_q)) |-> (clamp_win && !$past(clamp_win)));

endmodule

// File: tb/tb_hsync_clamp_gen.sv
module tb_hsync_clamp_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b1, clamp_in = 1'b0, coast_in = 1'b0;
  logic cfg_we = 1'b0, cfg_sync_pol = 1'b0, cfg_clamp_pol = 1'b0;
  logic cfg_coast_pol = 1'b1, cfg_ext_clamp = 1'b0;
  logic [7:0] cfg_delay = 8'd4, cfg_width = 8'd8;
  logic lead_strobe, clamp_win, coast_out;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  hsync_clamp_gen dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .clamp_in(clamp_in),
    .coast_in(coast_in), .cfg_we(cfg_we), .cfg_sync_pol(cfg_sync_pol),
    .cfg_clamp_pol(cfg_clamp_pol), .cfg_coast_pol(cfg_coast_pol),
    .cfg_ext_clamp(cfg_ext_clamp), .cfg_delay(cfg_delay), .cfg_width(cfg_width),
    .lead_strobe(lead_strobe), .clamp_win(clamp_win), .coast_out(coast_out)
  );

  typedef struct packed {
    logic       pol;
    logic [7:0] dly;
    logic [7:0] wid;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd3,  8'd4},
    '{1'b1, 8'd0,  8'd1},
    '{1'b0, 8'd10, 8'd2},
    '{1'b1, 8'd1,  8'd5},
    '{1'b0, 8'd0,  8'd0},
    '{1'b1, 8'd20, 8'd9}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic sp, input logic cp, input logic kp,
                         input logic ext, input logic [7:0] d, input logic [7:0] w);
    cfg_sync_pol = sp; cfg_clamp_pol = cp; cfg_coast_pol = kp;
    cfg_ext_clamp = ext; cfg_delay = d; cfg_width = w;
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic watch(input int n, output int first, output int len, input bit strobe);
    first = -1;
    len = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (strobe ? lead_strobe : clamp_win) begin
        if (first < 0) first = i;
        len++;
      end
    end
  endtask

  task automatic quiet(input logic pol);
    hsync_in = ~pol;
    repeat (300) tick();
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int f, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R9 reset lead_strobe", int'(lead_strobe), 0);
    chk("R9 reset clamp_win", int'(clamp_win), 0);
    chk("R9 reset coast_out", int'(coast_out), 0);

    coast_in = 1'b1;
    tick();
    tick();
    chk("R9 default coast active high", int'(coast_out), 1);
    coast_in = 1'b0;
    tick();
    tick();

    clamp_in = 1'b1;
    cfg_ext_clamp = 1'b1;
    cfg_width = 8'd1;
    tick();
    tick();
    chk("R7 clamp pin ignored in default mode", int'(clamp_win), 0);
    clamp_in = 1'b0;

    hsync_in = 1'b0;
    watch(6, f, l, 1'b1);
    chk("R1 default falling lead position", f, 2);
    chk("R1 default strobe width", l, 1);
    hsync_in = 1'b1;
    watch(30, f, l, 1'b0);
    chk("R9 default delay window start", f, 6);
    chk("R10 width unchanged without cfg_we", l, 8);

    for (int v = 0; v < NV; v++) begin
      quiet(VECS[v].pol);
      set_cfg(VECS[v].pol, 1'b0, 1'b1, 1'b0, VECS[v].dly, VECS[v].wid);
      hsync_in = VECS[v].pol;
      watch(6, f, l, 1'b1);
      chk("R1 table strobe position", f, 2);
      chk("R1 table strobe width", l, 1);
      hsync_in = ~VECS[v].pol;
      watch(int'(VECS[v].dly) + int'(VECS[v].wid) + 8, f, l, 1'b0);
      if (VECS[v].wid == 8'd0) begin
        chk("R5 table zero width start", f, -1);
        chk("R5 table zero width length", l, 0);
      end else begin
        chk("R3 table window start", f, 2 + int'(VECS[v].dly));
        chk("R3 table window length", l, int'(VECS[v].wid));
      end
    end

    quiet(1'b0);
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 8'd10, 8'd4);
    hsync_in = 1'b0;
    repeat (6) tick();
    hsync_in = 1'b1;
    repeat (3) tick();
    hsync_in = 1'b0;
    repeat (2) tick();
    hsync_in = 1'b1;
    watch(30, f, l, 1'b0);
    chk("R4 restart window start", f, 12);
    chk("R4 restart window length", l, 4);

    coast_in = 1'b1;
    repeat (3) tick();
    chk("R8 coast high level", int'(coast_out), 1);
    hsync_in = 1'b0;
    watch(6, f, l, 1'b1);
    chk("R2 strobe during coast", f, 2);
    chk("R2 strobe width during coast", l, 1);
    coast_in = 1'b0;
    hsync_in = 1'b1;
    repeat (30) tick();

    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 8'd4);
    repeat (3) tick();
    chk("R8 coast active low", int'(coast_out), 1);
    coast_in = 1'b1;
    tick();
    chk("R8 coast latency hold", int'(coast_out), 1);
    tick();
    chk("R8 coast released", int'(coast_out), 0);
    coast_in = 1'b0;

    set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 8'd0, 8'd5);
    clamp_in = 1'b1;
    tick();
    chk("R6 ext latency edge k", int'(clamp_win), 0);
    tick();
    chk("R6 ext high after k+1", int'(clamp_win), 1);
    clamp_in = 1'b0;
    repeat (3) tick();
    hsync_in = 1'b0;
    repeat (6) tick();
    hsync_in = 1'b1;
    watch(20, f, l, 1'b0);
    chk("R6 counters ignored in ext mode", l, 0);

    set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 8'd0, 8'd5);
    tick();
    chk("R6 ext active low idle", int'(clamp_win), 1);
    clamp_in = 1'b1;
    tick();
    tick();
    chk("R6 ext active low released", int'(clamp_win), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule